// File: doc/BRIEF.md
# Interrupt Vectoring and Context Save Unit

This unit sits beside a small processor core and handles the hardware side of taking an interrupt. It watches a few request lines and a global interrupt enable. When the enable is set and a request is pending in an idle cycle, it picks the lowest-numbered source. It sends that source a one-cycle acknowledge and asks the core to clear the global enable.

It then saves the running context to data memory as two bytes, starting at the stack pointer the core supplies. The first byte is the low eight bits of the 14-bit program counter. The second byte packs the six high program-counter bits with the carry and zero flags. Finally it gives the core the source's fixed vector address and the stack pointer advanced past the two bytes.

The two context bytes leave through a valid/ready write port. A byte is offered with `mem_wvalid`, and the transfer happens on a clock edge where `mem_wready` is also high. While `mem_wready` is low, the byte, its address and the whole sequence hold. The memory side may stall for any number of cycles. The request, enable, vector-load and stack-load pins are plain level or strobe signals.

Top module: `intr_ctx_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `mem_wvalid`, `irq_ack`, `gie_clr`, `pc_load` and `sp_load` are all 0.
- R2: While `gie_in` is 0, pending requests start no sequence: `irq_ack`, `gie_clr` and `mem_wvalid` stay 0.
- R3: When several requests are pending, the lowest index is chosen. Source i loads vector address 2*(i+1): source 0 gets 0x0002, source 1 gets 0x0004, source 2 gets 0x0006.
- R4: An accept happens on an edge in the idle state where `gie_in` is 1 and any request is set. In the cycle after it, `gie_clr` is 1 and `irq_ack` is one-hot on the chosen source, for exactly one cycle.
- R5: The first context byte is written to address `sp_in` and holds program-counter bits 7:0. The program counter, flags and stack pointer are all captured at the accept edge.
- R6: The second byte goes to the address after the first one. Bits 5:0 hold program-counter bits 13:8, bit 6 holds carry and bit 7 holds zero.
- R7: One cycle after the second byte is accepted, `pc_load` and `sp_load` pulse for one cycle. At the same time `pc_out` carries the vector and `sp_out` equals the captured stack pointer plus 2.
- R8: While `mem_wvalid` is 1 and `mem_wready` is 0, the address, the data and `mem_wvalid` stay unchanged on the next cycle.
- R9: A request that arrives during a sequence is not acknowledged before the sequence ends. It is accepted on the first edge back in the idle state.
- R10: Stack addresses wrap modulo 2^SP_W. A stack pointer of 0xFF puts the second byte at 0x00 and gives `sp_out` = 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | NSRC | Level request per source, index 0 highest priority |
| gie_in | input | 1 | Global interrupt enable from the core |
| pc_in | input | 14 | Current program counter |
| carry_in | input | 1 | Carry flag |
| zero_in | input | 1 | Zero flag |
| sp_in | input | SP_W | Current stack pointer |
| mem_wvalid | output | 1 | Context byte offered |
| mem_wready | input | 1 | Memory accepts the offered byte |
| mem_waddr | output | SP_W | Address of the offered byte |
| mem_wdata | output | 8 | Offered context byte |
| irq_ack | output | NSRC | One-hot acknowledge to the chosen source |
| gie_clr | output | 1 | Request to clear the global enable |
| pc_load | output | 1 | Load `pc_out` into the program counter |
| pc_out | output | 14 | Vector address |
| sp_load | output | 1 | Load `sp_out` into the stack pointer |
| sp_out | output | SP_W | Advanced stack pointer |

## Verification
The accept edge starts the timing for every result. The acknowledge, the enable clear and the first byte appear one edge after it. The second byte appears one edge after the first byte's handshake. The vector and stack loads appear one edge after the second byte's handshake, so with no stall the whole sequence takes three cycles.

The bench drives every input on a falling edge and compares outputs on the following falling edge. In stall runs it holds `mem_wready` low for a counted number of cycles and moves its expected timeline by exactly that count. It sweeps every non-empty request pattern against several program-counter, flag, stack-pointer and stall combinations, including the stack wrap at 0xFF.

// File: rtl/intr_ctx_pkg.sv
package intr_ctx_pkg;
  localparam int PC_W   = 14;
  localparam int BYTE_W = 8;
  localparam int HI_W   = PC_W - BYTE_W;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SAVE0 = 2'd1,
    ST_SAVE1 = 2'd2,
    ST_VEC   = 2'd3
  } ctx_state_e;

  // Source i lands two words above source i-1, starting at 2.
  function automatic logic [PC_W-1:0] vec_of(input int idx);
    return PC_W'(2 * (idx + 1));
  endfunction
endpackage

// File: rtl/intr_prio_pick.sv
module intr_prio_pick
  import intr_ctx_pkg::*;
#(
  parameter int NSRC = 3
) (
  input  logic [NSRC-1:0] req,
  output logic [NSRC-1:0] grant,
  output logic            any,
  output logic [PC_W-1:0] vector
);
  // Lowest index wins: a source is granted only when no lower source asks.
  for (genvar gi = 0; gi < NSRC; gi++) begin : g_grant
    if (gi == 0) begin : g_first
      assign grant[gi] = req[gi];
    end else begin : g_rest
      assign grant[gi] = req[gi] & ~(|req[gi-1:0]);
    end
  end

  assign any = |req;

  always_comb begin
    vector = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (grant[i]) vector = vec_of(i);
    end
  end

  // R3: exactly one granted source, and only a requesting one
  always_comb begin
    if (!$isunknown(req)) begin
      assert_grant_onehot_R3: assert (!any || ($onehot(grant) && ((grant & req) == grant)));
    end
  end
endmodule

// File: rtl/intr_ctx_pack.sv
module intr_ctx_pack
  import intr_ctx_pkg::*;
(
  input  logic [PC_W-1:0]   pc,
  input  logic              carry,
  input  logic              zero,
  output logic [BYTE_W-1:0] byte_lo,
  output logic [BYTE_W-1:0] byte_hi
);
  assign byte_lo = pc[BYTE_W-1:0];
  assign byte_hi = {zero, carry, pc[PC_W-1:BYTE_W]};
endmodule

// File: rtl/intr_ctx_seq.sv
module intr_ctx_seq
  import intr_ctx_pkg::*;
#(
  parameter int NSRC = 3,
  parameter int SP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gie_in,
  input  logic              any,
  input  logic [NSRC-1:0]   grant,
  input  logic [PC_W-1:0]   vector,
  input  logic [PC_W-1:0]   pc_in,
  input  logic              carry_in,
  input  logic              zero_in,
  input  logic [SP_W-1:0]   sp_in,
  input  logic [BYTE_W-1:0] byte_lo,
  input  logic [BYTE_W-1:0] byte_hi,
  output logic [PC_W-1:0]   pc_cap,
  output logic              carry_cap,
  output logic              zero_cap,
  output logic              mem_wvalid,
  input  logic              mem_wready,
  output logic [SP_W-1:0]   mem_waddr,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic [NSRC-1:0]   irq_ack,
  output logic              gie_clr,
  output logic              pc_load,
  output logic [PC_W-1:0]   pc_out,
  output logic              sp_load,
  output logic [SP_W-1:0]   sp_out
);
  ctx_state_e      state;
  logic [NSRC-1:0] ack_q;
  logic [PC_W-1:0] vec_q;
  logic [SP_W-1:0] sp_q;
  logic            accept;
  logic            fire;

  assign accept = (state == ST_IDLE) && gie_in && any;
  assign fire   = mem_wvalid && mem_wready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      ack_q     <= '0;
      vec_q     <= '0;
      sp_q      <= '0;
      pc_cap    <= '0;
      carry_cap <= 1'b0;
      zero_cap  <= 1'b0;
    end else begin
      ack_q <= '0;
      unique case (state)
        ST_IDLE: if (accept) begin
          state     <= ST_SAVE0;
          ack_q     <= grant;
          vec_q     <= vector;
          sp_q      <= sp_in;
          pc_cap    <= pc_in;
          carry_cap <= carry_in;
          zero_cap  <= zero_in;
        end
        ST_SAVE0: if (mem_wready) begin
          sp_q  <= sp_q + 1'b1;
          state <= ST_SAVE1;
        end
        ST_SAVE1: if (mem_wready) begin
          sp_q  <= sp_q + 1'b1;
          state <= ST_VEC;
        end
        ST_VEC: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign mem_wvalid = (state == ST_SAVE0) || (state == ST_SAVE1);
  assign mem_waddr  = sp_q;
  assign mem_wdata  = (state == ST_SAVE0) ? byte_lo : byte_hi;
  assign irq_ack    = ack_q;
  assign gie_clr    = |ack_q;
  assign pc_load    = (state == ST_VEC);
  assign sp_load    = (state == ST_VEC);
  assign pc_out     = vec_q;
  assign sp_out     = sp_q;

  assert_hold_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wvalid && !mem_wready) |=> (mem_wvalid && $stable(mem_waddr) && $stable(mem_wdata)));

  assert_ack_onehot0_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_ack));

  assert_ack_after_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ($onehot(irq_ack) && gie_clr && mem_wvalid));

  assert_load_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> $past(fire));

  assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (state == ST_SAVE0)) |=> (mem_waddr == $past(mem_waddr) + 1'b1));

  assert_no_ack_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |=> !gie_clr);
endmodule

// File: rtl/intr_ctx_unit.sv
module intr_ctx_unit
  import intr_ctx_pkg::*;
#(
  parameter int NSRC = 3,
  parameter int SP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   irq_req,
  input  logic              gie_in,
  input  logic [PC_W-1:0]   pc_in,
  input  logic              carry_in,
  input  logic              zero_in,
  input  logic [SP_W-1:0]   sp_in,
  output logic              mem_wvalid,
  input  logic              mem_wready,
  output logic [SP_W-1:0]   mem_waddr,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic [NSRC-1:0]   irq_ack,
  output logic              gie_clr,
  output logic              pc_load,
  output logic [PC_W-1:0]   pc_out,
  output logic              sp_load,
  output logic [SP_W-1:0]   sp_out
);
  logic [NSRC-1:0]   grant;
  logic              any;
  logic [PC_W-1:0]   vector;
  logic [PC_W-1:0]   pc_cap;
  logic              carry_cap;
  logic              zero_cap;
  logic [BYTE_W-1:0] byte_lo;
  logic [BYTE_W-1:0] byte_hi;

  intr_prio_pick #(.NSRC(NSRC)) u_pick (
    .req(irq_req), .grant(grant), .any(any), .vector(vector)
  );

  intr_ctx_pack u_pack (
    .pc(pc_cap), .carry(carry_cap), .zero(zero_cap),
    .byte_lo(byte_lo), .byte_hi(byte_hi)
  );

  intr_ctx_seq #(.NSRC(NSRC), .SP_W(SP_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .gie_in(gie_in), .any(any), .grant(grant),
    .vector(vector), .pc_in(pc_in), .carry_in(carry_in), .zero_in(zero_in),
    .sp_in(sp_in), .byte_lo(byte_lo), .byte_hi(byte_hi),
    .pc_cap(pc_cap), .carry_cap(carry_cap), .zero_cap(zero_cap),
    .mem_wvalid(mem_wvalid), .mem_wready(mem_wready), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata), .irq_ack(irq_ack), .gie_clr(gie_clr),
    .pc_load(pc_load), .pc_out(pc_out), .sp_load(sp_load), .sp_out(sp_out)
  );

  // R1: nothing is offered or loaded in the first cycle out of reset
  assert_quiet_reset_R1: assert property (@(posedge clk)
    !rst_n |=> (!mem_wvalid && !pc_load && !sp_load && !gie_clr));
endmodule

// File: tb/intr_ctx_unit_bench.sv
module intr_ctx_unit_bench;
  localparam int NSRC = 3;
  localparam int SP_W = 8;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NSRC-1:0] irq_req;
  logic            gie_in;
  logic [13:0]     pc_in;
  logic            carry_in, zero_in;
  logic [SP_W-1:0] sp_in;
  logic            mem_wvalid, mem_wready;
  logic [SP_W-1:0] mem_waddr;
  logic [7:0]      mem_wdata;
  logic [NSRC-1:0] irq_ack;
  logic            gie_clr, pc_load, sp_load;
  logic [13:0]     pc_out;
  logic [SP_W-1:0] sp_out;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #5 clk = ~clk;

  intr_ctx_unit #(.NSRC(NSRC), .SP_W(SP_W)) u_intr_ctx_unit (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .gie_in(gie_in),
    .pc_in(pc_in), .carry_in(carry_in), .zero_in(zero_in), .sp_in(sp_in),
    .mem_wvalid(mem_wvalid), .mem_wready(mem_wready), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata), .irq_ack(irq_ack), .gie_clr(gie_clr),
    .pc_load(pc_load), .pc_out(pc_out), .sp_load(sp_load), .sp_out(sp_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [NSRC-1:0] lowest(input logic [NSRC-1:0] r);
    for (int i = 0; i < NSRC; i++) if (r[i]) return NSRC'(1) << i;
    return '0;
  endfunction

  function automatic logic [13:0] vec_for(input logic [NSRC-1:0] oh);
    for (int i = 0; i < NSRC; i++) if (oh[i]) return 14'(2 * (i + 1));
    return '0;
  endfunction

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_one(input logic [NSRC-1:0] req, input logic [13:0] pc,
                         input logic c, input logic z, input logic [SP_W-1:0] sp,
                         input int stall);
    logic [NSRC-1:0] oh;
    oh = lowest(req);
    irq_req = req; gie_in = 1'b1; pc_in = pc; carry_in = c; zero_in = z;
    sp_in = sp; mem_wready = (stall == 0);
    step();
    // scramble inputs to show that the values were captured at accept
    irq_req = '0; gie_in = 1'b0; pc_in = ~pc; carry_in = ~c; zero_in = ~z; sp_in = ~sp;
    chk("R4 gie_clr", 32'(gie_clr), 32'd1);
    chk("R3/R4 ack onehot", 32'(irq_ack), 32'(oh));
    chk("R5 byte0 valid", 32'(mem_wvalid), 32'd1);
    chk("R5 byte0 addr", 32'(mem_waddr), 32'(sp));
    chk("R5 byte0 data", 32'(mem_wdata), 32'(pc[7:0]));
    for (int k = 0; k < stall; k++) begin
      step();
      chk("R8 stall valid", 32'(mem_wvalid), 32'd1);
      chk("R8 stall addr", 32'(mem_waddr), 32'(sp));
      chk("R8 stall data", 32'(mem_wdata), 32'(pc[7:0]));
      chk("R4 single pulse", 32'(gie_clr), 32'd0);
    end
    mem_wready = 1'b1;
    step();
    chk("R4 pulse gone", 32'(gie_clr), 32'd0);
    chk("R6 byte1 valid", 32'(mem_wvalid), 32'd1);
    chk("R6/R10 byte1 addr", 32'(mem_waddr), 32'(SP_W'(sp + 8'd1)));
    chk("R6 byte1 data", 32'(mem_wdata), 32'({z, c, pc[13:8]}));
    step();
    chk("R7 pc_load", 32'(pc_load), 32'd1);
    chk("R3/R7 vector", 32'(pc_out), 32'(vec_for(oh)));
    chk("R7 sp_load", 32'(sp_load), 32'd1);
    chk("R7/R10 sp_out", 32'(sp_out), 32'(SP_W'(sp + 8'd2)));
    chk("R7 no write", 32'(mem_wvalid), 32'd0);
    step();
    chk("R7 single load", 32'(pc_load), 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; irq_req = '0; gie_in = 1'b0; pc_in = '0; carry_in = 1'b0;
    zero_in = 1'b0; sp_in = '0; mem_wready = 1'b1;
    repeat (3) @(negedge clk);
    // R1: quiet during reset
    chk("R1 wvalid", 32'(mem_wvalid), 32'd0);
    chk("R1 ack", 32'({irq_ack, gie_clr}), 32'd0);
    chk("R1 loads", 32'({pc_load, sp_load}), 32'd0);
    rst_n = 1'b1;
    step();
    chk("R1 after release", 32'({mem_wvalid, pc_load, sp_load, gie_clr}), 32'd0);

    // R2: requests with enable low are ignored
    irq_req = '1;
    for (int k = 0; k < 5; k++) begin
      step();
      chk("R2 no ack", 32'({irq_ack, gie_clr}), 32'd0);
      chk("R2 no write", 32'(mem_wvalid), 32'd0);
    end
    irq_req = '0;
    step();

    // Sweep every request pattern against several contexts
    for (int r = 1; r < (1 << NSRC); r++) begin
      for (int d = 0; d < 4; d++) begin
        logic [13:0]     pcv;
        logic [SP_W-1:0] spv;
        pcv = 14'((r * 32'h1357 + d * 32'h0A5C) & 32'h3FFF);
        spv = (d == 3) ? 8'hFF : 8'(r * 16 + d * 5);
        run_one(NSRC'(r), pcv, d[0], d[1], spv, d % 3);
      end
    end

    // R9: a request raised during a sequence waits for idle
    irq_req = 3'b001; gie_in = 1'b1; pc_in = 14'h2ABC; sp_in = 8'h40;
    carry_in = 1'b1; zero_in = 1'b0; mem_wready = 1'b1;
    step();
    irq_req = 3'b100;
    chk("R9 first ack", 32'(irq_ack), 32'b001);
    step();
    chk("R9 held off save1", 32'(gie_clr), 32'd0);
    step();
    chk("R9 held off vec", 32'(gie_clr), 32'd0);
    chk("R9 vec source0", 32'(pc_out), 32'h0002);
    step();
    chk("R9 idle no ack", 32'(gie_clr), 32'd0);
    step();
    chk("R9 later ack", 32'(irq_ack), 32'b100);
    irq_req = '0; gie_in = 1'b0;
    repeat (3) step();
    chk("R9 vector 6", 32'(pc_out), 32'h0006);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule